// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This unit executes the two partial message-expansion steps of the SM3 hash as a single registered vector operation. Each operation takes three 128-bit operands, named d, n and m. Each operand is treated as four 32-bit lanes. A one-bit select chooses partial step 1 or partial step 2. A valid strobe qualifies the operands, and the result appears exactly one clock later together with a valid flag.

The lanes are not independent. In step 1, lane 3 is computed from the new lane-0 result of the same operation. In step 2, a lane-0 intermediate value is permuted and folded into lane 3. Both steps are evaluated combinationally from the operands. The selected result is captured in one output register.

A two-state controller generates the valid flag. It has two states. ST_IDLE means no result is being presented. ST_VALID means the output register holds a result that was captured on the previous edge. The transitions are as follows:

- ST_IDLE goes to ST_VALID on a strobe.
- ST_VALID stays in ST_VALID on a further strobe.
- ST_VALID returns to ST_IDLE when no strobe is present.
- Reset forces ST_IDLE from either state.

Top module: `sm3_msg_expand`

## Requirements
- R1: Lane i of every operand and of the result occupies bits 32*i+31 down to 32*i, so lane 0 is the least significant word.
- R2: With in_op = 0 (step 1), lanes 0, 1 and 2 of the result equal P(t), where t = d[i] ^ n[i] ^ ror(m[i+1],17) and P(x) = x ^ ror(x,17) ^ ror(x,9). Here ror is a right rotation within a 32-bit lane.
- R3: In step 1, lane 3 of the result equals P(d[3] ^ n[3] ^ ror(r0,17)), where r0 is the lane-0 result of the same operation.
- R4: With in_op = 1 (step 2), lane 0 of the result equals d[0] ^ t, where t = n[0] ^ ror(m[0],25).
- R5: In step 2, lanes 1 and 2 of the result equal d[i] ^ n[i] ^ ror(m[i],25).
- R6: In step 2, lane 3 of the result equals d[3] ^ n[3] ^ ror(m[3],25) ^ ror(t,17) ^ ror(t,2) ^ ror(t,26), where t is the lane-0 intermediate from R4.
- R7: When in_valid is high at a clock edge, out_valid is high after that edge and out_result carries the result of that cycle's operands.
- R8: When in_valid is low at a clock edge, out_valid is low after that edge, out_result keeps its previous value, and the operand and select inputs have no effect.
- R9: When rst is high at a clock edge (synchronous, active high), out_valid is low and out_result is all zeros after that edge, even if in_valid is also high.
- R10: Strobes on consecutive cycles give results on consecutive cycles, each one matching its own operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| in_op | input | 1 | Step select: 0 = partial step 1, 1 = partial step 2 |
| in_d | input | 128 | Operand d, four 32-bit lanes |
| in_n | input | 128 | Operand n, four 32-bit lanes |
| in_m | input | 128 | Operand m, four 32-bit lanes |
| out_valid | output | 1 | out_result holds the result of the previous cycle's strobe |
| out_result | output | 128 | Registered result, four 32-bit lanes |

## Verification
Every result is due one rising edge after the strobe that carries its operands. A reset or an idle cycle likewise shows its effect one edge later.

The bench drives inputs on the falling edge. It samples 1 ns after the next rising edge, so each check looks at the register value produced by exactly that stimulus. The table of vectors is driven on back-to-back cycles to exercise R10. Directed cycles then check the hold after a gap, the lane layout, and a reset that arrives together with a strobe, each in the cycle after its stimulus.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;

    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = LANE_W * LANES;

    // rotation amounts of the two expansion steps
    localparam int P1_ROT_M = 17;
    localparam int P1_MIX_A = 17;
    localparam int P1_MIX_B = 9;
    localparam int P2_ROT_M = 25;
    localparam int P2_MIX_A = 17;
    localparam int P2_MIX_B = 2;
    localparam int P2_MIX_C = 26;

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic {
        OP_PART1 = 1'b0,
        OP_PART2 = 1'b1
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } st_e;

    function automatic lane_t ror(lane_t x, int k);
        ror = (x >> k) | (x << (LANE_W - k));
    endfunction

    function automatic lane_t p1_mix(lane_t x);
        p1_mix = x ^ ror(x, P1_MIX_A) ^ ror(x, P1_MIX_B);
    endfunction

endpackage

// File: rtl/sm3x_part1.sv
module sm3x_part1
    import sm3x_pkg::*;
(
    input  logic [VEC_W-1:0] d,
    input  logic [VEC_W-1:0] n,
    input  logic [VEC_W-1:0] m,
    output logic [VEC_W-1:0] r
);

    localparam int LAST = LANES - 1;

    lane_t lane_r [LANES];

    // lanes that take their rotated term from the next m lane
    for (genvar i = 0; i < LAST; i++) begin : g_lane
        lane_t t;
        always_comb begin
            t         = d[i*LANE_W +: LANE_W] ^ n[i*LANE_W +: LANE_W]
                      ^ ror(m[(i+1)*LANE_W +: LANE_W], P1_ROT_M);
            lane_r[i] = p1_mix(t);
        end
    end

    // the top lane chains on the freshly computed lane 0
    lane_t t_last;
    always_comb begin
        t_last       = d[LAST*LANE_W +: LANE_W] ^ n[LAST*LANE_W +: LANE_W]
                     ^ ror(lane_r[0], P1_ROT_M);
        lane_r[LAST] = p1_mix(t_last);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_pack
        assign r[i*LANE_W +: LANE_W] = lane_r[i];
    end

endmodule

// File: rtl/sm3x_part2.sv
module sm3x_part2
    import sm3x_pkg::*;
(
    input  logic [VEC_W-1:0] d,
    input  logic [VEC_W-1:0] n,
    input  logic [VEC_W-1:0] m,
    output logic [VEC_W-1:0] r
);

    localparam int LAST = LANES - 1;

    lane_t base [LANES];
    lane_t t0;
    lane_t fold;

    for (genvar i = 0; i < LANES; i++) begin : g_base
        assign base[i] = d[i*LANE_W +: LANE_W] ^ n[i*LANE_W +: LANE_W]
                       ^ ror(m[i*LANE_W +: LANE_W], P2_ROT_M);
    end

    // lane-0 intermediate, independent of d
    assign t0   = n[LANE_W-1:0] ^ ror(m[LANE_W-1:0], P2_ROT_M);
    assign fold = ror(t0, P2_MIX_A) ^ ror(t0, P2_MIX_B) ^ ror(t0, P2_MIX_C);

    for (genvar i = 0; i < LANES; i++) begin : g_pack
        if (i == LAST) begin : g_top
            assign r[i*LANE_W +: LANE_W] = base[i] ^ fold;
        end else begin : g_plain
            assign r[i*LANE_W +: LANE_W] = base[i];
        end
    end

endmodule

// File: rtl/sm3x_ctrl.sv
module sm3x_ctrl
    import sm3x_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic [VEC_W-1:0] part1_res,
    input  logic [VEC_W-1:0] part2_res,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result
);

    st_e              state_q;
    st_e              state_d;
    logic [VEC_W-1:0] res_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (in_valid) begin
            unique case (op_e'(in_op))
                OP_PART1: res_q <= part1_res;
                OP_PART2: res_q <= part2_res;
                default:  res_q <= part1_res;
            endcase
        end
    end

    assign out_valid  = (state_q == ST_VALID);
    assign out_result = res_q;

endmodule

// File: rtl/sm3_msg_expand.sv
module sm3_msg_expand
    import sm3x_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic [VEC_W-1:0] in_d,
    input  logic [VEC_W-1:0] in_n,
    input  logic [VEC_W-1:0] in_m,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result
);

    logic [VEC_W-1:0] part1_res;
    logic [VEC_W-1:0] part2_res;

    sm3x_part1 u_part1 (
        .d (in_d),
        .n (in_n),
        .m (in_m),
        .r (part1_res)
    );

    sm3x_part2 u_part2 (
        .d (in_d),
        .n (in_n),
        .m (in_m),
        .r (part2_res)
    );

    sm3x_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .part1_res  (part1_res),
        .part2_res  (part2_res),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

endmodule

// File: rtl/sm3_msg_expand_chk.sv
module sm3_msg_expand_chk
    import sm3x_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_op,
    input logic [VEC_W-1:0] in_d,
    input logic [VEC_W-1:0] in_n,
    input logic [VEC_W-1:0] in_m,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_result
);

    // R7
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    idle_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_result == '0)));

    // R4
    part2_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op) |=> out_result[31:0] ==
            $past(in_d[31:0] ^ in_n[31:0] ^ ror(in_m[31:0], P2_ROT_M)));

    // R5
    part2_lane1_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op) |=> out_result[63:32] ==
            $past(in_d[63:32] ^ in_n[63:32] ^ ror(in_m[63:32], P2_ROT_M)));

endmodule

bind sm3_msg_expand sm3_msg_expand_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_d       (in_d),
    .in_n       (in_n),
    .in_m       (in_m),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/test_sm3_msg_expand.sv
`timescale 1ns/1ps
module test_sm3_msg_expand;

    typedef struct packed {
        logic         op;
        logic [127:0] d;
        logic [127:0] n;
        logic [127:0] m;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 128'h0, 128'h0, 128'h0},
        '{1'b0, {128{1'b1}}, {128{1'b1}}, {128{1'b1}}},
        '{1'b0, 128'h1, 128'h0, 128'h0},
        '{1'b0, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
                128'hdead_beef_0bad_f00d_1357_9bdf_2468_ace0,
                128'h3c3c_a5a5_0f0f_f0f0_9669_6996_c33c_5aa5},
        '{1'b1, 128'h0, 128'h0, 128'h0},
        '{1'b1, 128'h0, 128'h1, 128'h0},
        '{1'b1, 128'h8899_aabb_ccdd_eeff_0011_2233_4455_6677,
                128'h1f2e_3d4c_5b6a_7988_a7b6_c5d4_e3f2_0112,
                128'hcafe_babe_5eed_1234_7777_8888_abcd_ef01},
        '{1'b1, 128'h0, 128'h0, 128'h1},
        '{1'b0, 128'h0, 128'h0, 128'h8000_0000_0000_0000_0000_0000_0000_0000},
        '{1'b1, {128{1'b1}}, {128{1'b1}}, {128{1'b1}}}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_op = 1'b0;
    logic [127:0] in_d = '0;
    logic [127:0] in_n = '0;
    logic [127:0] in_m = '0;
    logic         out_valid;
    logic [127:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sm3_msg_expand i_sm3_msg_expand (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_d       (in_d),
        .in_n       (in_n),
        .in_m       (in_m),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic logic [31:0] rr(logic [31:0] x, int s);
        logic [63:0] w;
        w  = {x, x} >> s;
        rr = w[31:0];
    endfunction

    function automatic logic [31:0] wd(logic [127:0] v, int k);
        wd = v[32*k +: 32];
    endfunction

    function automatic logic [127:0] model(vec_t v);
        logic [31:0] r0, r1, r2, r3, t;
        if (!v.op) begin
            t  = wd(v.d,0) ^ wd(v.n,0) ^ rr(wd(v.m,1),17); r0 = t ^ rr(t,17) ^ rr(t,9);
            t  = wd(v.d,1) ^ wd(v.n,1) ^ rr(wd(v.m,2),17); r1 = t ^ rr(t,17) ^ rr(t,9);
            t  = wd(v.d,2) ^ wd(v.n,2) ^ rr(wd(v.m,3),17); r2 = t ^ rr(t,17) ^ rr(t,9);
            t  = wd(v.d,3) ^ wd(v.n,3) ^ rr(r0,17);        r3 = t ^ rr(t,17) ^ rr(t,9);
        end else begin
            t  = wd(v.n,0) ^ rr(wd(v.m,0),25);
            r0 = wd(v.d,0) ^ t;
            r1 = wd(v.d,1) ^ wd(v.n,1) ^ rr(wd(v.m,1),25);
            r2 = wd(v.d,2) ^ wd(v.n,2) ^ rr(wd(v.m,2),25);
            r3 = wd(v.d,3) ^ wd(v.n,3) ^ rr(wd(v.m,3),25) ^ rr(t,17) ^ rr(t,2) ^ rr(t,26);
        end
        model = {r3, r2, r1, r0};
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(bit v, vec_t x);
        @(negedge clk);
        in_valid = v;
        in_op    = x.op;
        in_d     = x.d;
        in_n     = x.n;
        in_m     = x.m;
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] exp;
        logic [127:0] last;
        vec_t x;

        // R9 reset state
        settle();
        settle();
        chk("R9 reset out_valid", {127'b0, out_valid}, 128'h0);
        chk("R9 reset out_result", out_result, 128'h0);
        @(negedge clk);
        rst = 1'b0;

        // table walked back to back (R10)
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i]);
            settle();
            exp = model(VECS[i]);
            chk("R7 R10 out_valid", {127'b0, out_valid}, 128'h1);
            if (!VECS[i].op) begin
                chk("R2 step1 lanes0-2", {32'h0, out_result[95:0]}, {32'h0, exp[95:0]});
                chk("R3 step1 lane3", {96'h0, out_result[127:96]}, {96'h0, exp[127:96]});
            end else begin
                chk("R4 step2 lane0", {96'h0, out_result[31:0]}, {96'h0, exp[31:0]});
                chk("R5 step2 lanes1-2", {64'h0, out_result[95:32]}, {64'h0, exp[95:32]});
                chk("R6 step2 lane3", {96'h0, out_result[127:96]}, {96'h0, exp[127:96]});
            end
        end
        last = model(VECS[NV-1]);

        // R8 gap: inputs change without strobe
        x = '{1'b0, 128'h5555_0000_1111_2222_3333_4444_5555_6666,
                    128'h7, 128'h9999_aaaa_bbbb_cccc_dddd_eeee_ffff_0000};
        drive(1'b0, x);
        settle();
        chk("R8 gap out_valid", {127'b0, out_valid}, 128'h0);
        chk("R8 gap result held", out_result, last);
        x.op = 1'b1;
        drive(1'b0, x);
        settle();
        chk("R8 second gap result held", out_result, last);

        // R1 lane layout: step 2 with only d lane 0 set
        x = '{1'b1, 128'h0000_0000_0000_0000_0000_0000_a5c3_0f1e, 128'h0, 128'h0};
        drive(1'b1, x);
        settle();
        chk("R1 lane0 at low bits", out_result, {96'h0, 32'ha5c3_0f1e});
        chk("R7 after idle out_valid", {127'b0, out_valid}, 128'h1);

        // R3 dependence: lane-0 change alone moves lane 3 in step 1
        x = '{1'b0, 128'h0000_0000_0000_0000_0000_0000_0000_0100, 128'h0, 128'h0};
        drive(1'b1, x);
        settle();
        exp = model(x);
        chk("R3 lane3 from new lane0", out_result, exp);

        // R9 reset together with a strobe
        drive(1'b1, VECS[3]);
        rst = 1'b1;
        settle();
        chk("R9 reset beats strobe out_valid", {127'b0, out_valid}, 128'h0);
        chk("R9 reset beats strobe out_result", out_result, 128'h0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        settle();
        chk("R8 idle after reset out_valid", {127'b0, out_valid}, 128'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule